// File: doc/BRIEF.md
# Parallel Lag Autocorrelation Engine

This block computes the first `NUM_LAGS` autocorrelation terms of a frame of signed samples. The samples are assumed to be windowed already. One sample arrives per clock on a valid-qualified stream. A shift register keeps the most recent samples. Each lag has its own multiply-accumulate cell, and every cell adds one product per accepted sample. Each cell multiplies the current sample by the sample that arrived `k` accepted positions earlier.

All lags therefore build up together. When the last sample of a frame is accepted, every coefficient is final. The frame holds `FRAME_LEN` samples. The results need no intermediate memory and no second pass over the data. The number of cells and the frame length are separate parameters.

An upstream controller starts each frame with a one-cycle `frame_start` pulse. It then streams the samples, waits for `done`, and reads the coefficient bus. The bus holds its value until the next `frame_start`.

Top module: `autocorr_array`

## Requirements
- R1: While `rst` is high (synchronous, active high) and in the cycle after it falls, `done` is 0 and every lag word is 0. The block is then ready to accept a frame without a `frame_start`.
- R2: After a full frame of `FRAME_LEN` accepted samples s(0)..s(N-1), lag word k equals the sum of s(n)·s(n-k) for n from k to N-1.
  - Lag word k occupies bits `[k*ACC_W +: ACC_W]` of `r_out`.
  - Each word is in two's complement.
- R3: No sample from an earlier frame, or from before a reset, contributes to any lag of the current frame. For sample index i < k, the older operand of lag k is zero.
- R4: Lag words update in the cycle after each accepted sample, as running partial sums over the samples accepted so far. Lag k first becomes non-zero only after sample index k.
- R5: `done` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the `FRAME_LEN`-th sample of the frame.
- R6: After a frame completes, the lag words stay unchanged until the next `frame_start`. Valid samples arriving in that time are ignored.
- R7: Cycles with `sample_valid` low neither advance the sample count nor the delay chain, and they change no accumulator.
- R8: A `frame_start` pulse zeroes every lag word and the delay chain from the next cycle onward. A sample presented together with `frame_start` is ignored.
- R9: Full-scale frames accumulate exactly, without wrap, in the 40-bit words. This covers all samples at -32768 and alternating +32767/-32768.
- R10: A `frame_start` during an unfinished frame abandons that frame. The next `FRAME_LEN` samples form a fresh frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the whole array |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that clears state and opens a new frame |
| sample_valid | input | 1 | Qualifies `sample_in` |
| sample_in | input | DATA_W | Signed windowed sample |
| r_out | output | NUM_LAGS*ACC_W | Packed lag words, lag k at bits [k*ACC_W +: ACC_W] |
| done | output | 1 | One-cycle pulse when the frame's coefficients are final |

## Verification
The bench targets the following corner cases:

- **Delay-chain leakage.** The frame right after a full-scale frame would go wrong at its first few samples if the delay chain were not cleared. The higher lags would then carry large stale products.
- **Extreme samples.** Frames of -32768 and alternating extremes expose any truncated sign extension or undersized accumulator. Either fault shows up as a wrapped or sign-flipped r(0).
- **Gaps in the stream.** Random `sample_valid` gaps catch a delay chain or counter that advances on idle cycles. The result is shifted lags or an early `done`.
- **Samples at the frame edges.** Samples sent after `done`, and a sample that arrives with `frame_start`, catch a design that keeps accumulating into a finished or freshly cleared frame.

// File: rtl/autocorr_pkg.sv
package autocorr_pkg;

  // Frame sequencing state
  typedef enum logic [0:0] {
    FRM_HOLD = 1'b0,  // frame complete, results frozen
    FRM_RUN  = 1'b1   // accepting samples
  } frame_state_t;

  // Width of a counter able to hold values 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/ac_delay_line.sv
module ac_delay_line #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    shift_en,
  input  logic [DATA_W-1:0]       din,
  output logic [DEPTH*DATA_W-1:0] taps_flat
);

  logic [DATA_W-1:0] stage_q [DEPTH];

  generate
    for (genvar j = 0; j < DEPTH; j++) begin : g_stage
      logic [DATA_W-1:0] stage_d;
      if (j == 0) begin : g_head
        assign stage_d = din;
      end else begin : g_body
        assign stage_d = stage_q[j-1];
      end

      always_ff @(posedge clk) begin
        if (rst || clear) begin
          stage_q[j] <= '0;
        end else if (shift_en) begin
          stage_q[j] <= stage_d;
        end
      end

      assign taps_flat[j*DATA_W +: DATA_W] = stage_q[j];
    end
  endgenerate

  // R7
  property p_shift;
    @(posedge clk) disable iff (rst)
      (shift_en && !clear) |=> (stage_q[0] == $past(din));
  endproperty
  shift_capture_chk: assert property (p_shift);

  // R8
  property p_clear;
    @(posedge clk) disable iff (rst)
      clear |=> (stage_q[0] == '0);
  endproperty
  chain_clear_chk: assert property (p_clear);

endmodule

// File: rtl/ac_mac_cell.sv
module ac_mac_cell #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     acc_en,
  input  logic signed [DATA_W-1:0] cur_s,
  input  logic signed [DATA_W-1:0] old_s,
  output logic signed [ACC_W-1:0]  acc_q
);

  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;

  always_comb begin
    prod     = cur_s * old_s;
    prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_q + prod_ext;
    end
  end

  // R8
  property p_acc_clear;
    @(posedge clk) disable iff (rst)
      clear |=> (acc_q == '0);
  endproperty
  acc_clear_chk: assert property (p_acc_clear);

  // R6
  property p_acc_hold;
    @(posedge clk) disable iff (rst)
      (!acc_en && !clear) |=> $stable(acc_q);
  endproperty
  acc_hold_chk: assert property (p_acc_hold);

endmodule

// File: rtl/ac_frame_ctrl.sv
module ac_frame_ctrl
  import autocorr_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 240
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic sample_valid,
  output logic accept,
  output logic done
);

  localparam int unsigned CNT_W = cnt_width(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

  frame_state_t      state_q;
  logic [CNT_W-1:0]  count_q;

  assign accept = sample_valid && !frame_start && (state_q == FRM_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FRM_RUN;
      count_q <= '0;
      done    <= 1'b0;
    end else if (frame_start) begin
      state_q <= FRM_RUN;
      count_q <= '0;
      done    <= 1'b0;
    end else if (accept) begin
      if (count_q == LAST_IDX) begin
        state_q <= FRM_HOLD;
        count_q <= '0;
        done    <= 1'b1;
      end else begin
        count_q <= count_q + 1'b1;
        done    <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R5
  property p_done_pulse;
    @(posedge clk) disable iff (rst)
      done |=> !done;
  endproperty
  done_pulse_chk: assert property (p_done_pulse);

  // R2
  property p_count_range;
    @(posedge clk) disable iff (rst)
      count_q <= LAST_IDX;
  endproperty
  count_range_chk: assert property (p_count_range);

  // R6
  property p_hold_after_done;
    @(posedge clk) disable iff (rst)
      (done && !frame_start) |-> !accept;
  endproperty
  hold_after_done_chk: assert property (p_hold_after_done);

endmodule

// File: rtl/autocorr_array.sv
module autocorr_array #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ACC_W     = 40,
  parameter int unsigned NUM_LAGS  = 10,
  parameter int unsigned FRAME_LEN = 240
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_start,
  input  logic                      sample_valid,
  input  logic [DATA_W-1:0]         sample_in,
  output logic [NUM_LAGS*ACC_W-1:0] r_out,
  output logic                      done
);

  localparam int unsigned CHAIN_D = NUM_LAGS - 1;

  logic                      accept;
  logic [CHAIN_D*DATA_W-1:0] taps_flat;

  ac_frame_ctrl #(
    .FRAME_LEN (FRAME_LEN)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .sample_valid (sample_valid),
    .accept       (accept),
    .done         (done)
  );

  ac_delay_line #(
    .DATA_W (DATA_W),
    .DEPTH  (CHAIN_D)
  ) u_chain (
    .clk       (clk),
    .rst       (rst),
    .clear     (frame_start),
    .shift_en  (accept),
    .din       (sample_in),
    .taps_flat (taps_flat)
  );

  generate
    for (genvar k = 0; k < NUM_LAGS; k++) begin : g_lag
      logic [DATA_W-1:0]       older;
      logic signed [ACC_W-1:0] acc;
      if (k == 0) begin : g_zero
        assign older = sample_in;
      end else begin : g_tap
        assign older = taps_flat[(k-1)*DATA_W +: DATA_W];
      end

      ac_mac_cell #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
      ) u_cell (
        .clk    (clk),
        .rst    (rst),
        .clear  (frame_start),
        .acc_en (accept),
        .cur_s  (sample_in),
        .old_s  (older),
        .acc_q  (acc)
      );

      assign r_out[k*ACC_W +: ACC_W] = acc;
    end
  endgenerate

  // R5
  property p_done_cause;
    @(posedge clk) disable iff (rst)
      done |-> $past(accept);
  endproperty
  done_after_sample_chk: assert property (p_done_cause);

  // R9: the zero-lag energy term can never be negative
  property p_energy_sign;
    @(posedge clk) disable iff (rst)
      !r_out[ACC_W-1];
  endproperty
  no_overflow_chk: assert property (p_energy_sign);

endmodule

// File: tb/autocorr_array_tb.sv
module autocorr_array_tb;

  localparam int DATA_W    = 16;
  localparam int ACC_W     = 40;
  localparam int NUM_LAGS  = 10;
  localparam int FRAME_LEN = 240;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic                      frame_start = 1'b0;
  logic                      sample_valid = 1'b0;
  logic [DATA_W-1:0]         sample_in = '0;
  logic [NUM_LAGS*ACC_W-1:0] r_out;
  logic                      done;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  int     hist[$];
  longint exp_r[NUM_LAGS];
  bit     exp_done;
  bit     active;

  always #5 clk = ~clk;

  autocorr_array #(
    .DATA_W    (DATA_W),
    .ACC_W     (ACC_W),
    .NUM_LAGS  (NUM_LAGS),
    .FRAME_LEN (FRAME_LEN)
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .sample_valid (sample_valid),
    .sample_in    (sample_in),
    .r_out        (r_out),
    .done         (done)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint lag_word(int k);
    logic signed [ACC_W-1:0] w;
    w = r_out[k*ACC_W +: ACC_W];
    return longint'(w);
  endfunction

  task automatic model_clear();
    hist.delete();
    for (int k = 0; k < NUM_LAGS; k++) exp_r[k] = 0;
    exp_done = 1'b0;
    active   = 1'b1;
  endtask

  task automatic compare_all(string tag);
    check("R5", longint'(done), longint'(exp_done));
    for (int k = 0; k < NUM_LAGS; k++) check(tag, lag_word(k), exp_r[k]);
  endtask

  // one clock: drive, let the edge pass, advance model, compare
  task automatic step(bit fs, bit v, int s, string tag);
    frame_start  = fs;
    sample_valid = v;
    sample_in    = DATA_W'(s);
    @(posedge clk);
    if (rst || fs) begin
      model_clear();
    end else if (v && active) begin
      int sv;
      sv = int'($signed(DATA_W'(s)));
      hist.push_back(sv);
      for (int k = 0; k < NUM_LAGS; k++)
        if (hist.size() > k)
          exp_r[k] += longint'(sv) * longint'(hist[hist.size()-1-k]);
      if (hist.size() == FRAME_LEN) begin
        active   = 1'b0;
        exp_done = 1'b1;
      end else begin
        exp_done = 1'b0;
      end
    end else begin
      exp_done = 1'b0;
    end
    #1;
    compare_all(tag);
  endtask

  // mode 0 random, 1 all -32768, 2 alternating extremes
  task automatic feed_frame(int mode, string tag, int lead_tag_len, string lead_tag);
    for (int i = 0; i < FRAME_LEN; i++) begin
      int s;
      case (mode)
        1:       s = -32768;
        2:       s = (i % 2 == 0) ? 32767 : -32768;
        default: s = int'($urandom_range(0, 65535)) - 32768;
      endcase
      step(1'b0, 1'b1, s, (i < lead_tag_len) ? lead_tag : tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_clear();
    step(1'b0, 1'b1, 1234, "R1");
    step(1'b0, 1'b1, 555, "R1");
    rst = 1'b0;
    step(1'b0, 1'b0, 0, "R1");

    // random frame straight after reset
    feed_frame(0, "R2", NUM_LAGS, "R4");
    step(1'b0, 1'b0, 0, "R5");

    // samples after completion are ignored
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 20000 - i, "R6");
    step(1'b0, 1'b0, 0, "R6");

    // frame start with a sample alongside: sample dropped
    step(1'b1, 1'b1, 32767, "R8");
    feed_frame(1, "R9", 0, "R9");
    step(1'b0, 1'b0, 0, "R9");

    // frame after a full-scale frame: no stale samples
    step(1'b1, 1'b0, 0, "R8");
    feed_frame(0, "R2", NUM_LAGS + 2, "R3");

    step(1'b1, 1'b0, 0, "R8");
    feed_frame(2, "R9", 0, "R9");

    // gapped stream
    step(1'b1, 1'b0, 0, "R8");
    for (int n = 0; n < FRAME_LEN; ) begin
      bit v;
      v = ($urandom_range(0, 1) == 1);
      step(1'b0, v, int'($urandom_range(0, 65535)) - 32768, "R7");
      if (v) n++;
    end
    step(1'b0, 1'b0, 0, "R7");

    // abort mid-frame, then a clean frame
    step(1'b1, 1'b0, 0, "R8");
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, 30000, "R10");
    step(1'b1, 1'b0, 0, "R10");
    feed_frame(0, "R10", NUM_LAGS, "R3");
    step(1'b0, 1'b1, 777, "R6");
    step(1'b0, 1'b0, 0, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule